// File: doc/BRIEF.md
# Serial Result Port with Programmable Output Length

This block is the slave side of a synchronous serial link for a 10-bit converter. While chip select is held low, a host clocks an 8-bit configuration word in on the data input. On the same serial clock it reads the previous conversion result on the data output. The output word carries 8, 10, 12 or 16 bits, and its bit order can be MSB first or LSB first. Both settings come from fields in the incoming word.

All port inputs are sampled by a fast system clock. Chip select passes through a deglitch filter, so a noise pulse on that line does not start a transfer. The conversion itself is not part of this block: a result enters as a 10-bit parallel word with a one-cycle strobe.

The length field sits at the end of the input word, so it is known only late in the transfer. It still sets the length of the word being read in that same transfer. The order field is stored and governs the next output word. The data output starts before the length is known: the result is driven from its first bit, and positions past bit 10 are filled with zeros.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the data output is not driven, no configuration pulse is present, and the output order is MSB first.
- R2: While chip select is recognised high, serial clock edges change nothing and the data output is not driven.
- R3: Chip select changes only after its synchronised level has differed from the recognised level for GLITCH_CYC consecutive clock cycles. A low pulse of one clock cycle is not seen as a transfer.
- R4: Input bits are sampled on rising serial clock edges, first bit first, whatever order is selected. After the 8th bit, cfg_word_o holds the word with the first bit in bit 7, and cfg_valid_o pulses once. Word bit 2 (the sixth bit received) appears on cfg_msbf_o, and word bits 1:0 (the seventh and eighth bits received) appear on cfg_wl_o.
- R5: The length code of the current transfer's word selects the output length: 00 gives 8 bits, 01 gives 10, 10 gives 12 and 11 gives 16. After that many falling serial clock edges the data output is released.
- R6: In MSB-first order, output bit k (k counts from 0) is result bit 9-k for k below 10, and 0 after that. Output moves to the next bit on each falling serial clock edge.
- R7: In LSB-first order, output bit k is result bit k for k below 10, and 0 after that. An 8-bit word therefore carries only result bits 0 to 7.
- R8: The order bit of a transfer's word (1 = MSB first, 0 = LSB first) takes effect only from the next transfer.
- R9: A result strobe arrives during a transfer (chip select low and at least one rising serial clock edge already seen). The block ignores it: the current word keeps the old result, and the next transfer does not drive the output, because no new result was accepted.
- R10: If chip select is held low before a result arrives, the data output stays released. Once the result is accepted, the output drives the first output bit without any serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all port inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial configuration input |
| dout_o | output | 1 | Serial result output, high impedance when released |
| dout_oe_o | output | 1 | High while dout_o is driven |
| res_i | input | 10 | Parallel conversion result |
| res_vld_i | input | 1 | One-cycle strobe that offers res_i |
| cfg_word_o | output | 8 | Last complete input word |
| cfg_msbf_o | output | 1 | Order bit of the last word |
| cfg_wl_o | output | 2 | Length code of the last word |
| cfg_valid_o | output | 1 | One-cycle pulse when a word completes |

## Verification
The bench sweeps every length code in both orders, with three result values for each combination. Each sweep steps the order bit in its input word, so a design that applied the order at once, swapped the bit mapping, or dropped the zero fill past bit 10 would give a wrong bit, and a wrong release point would show on the output enable. Further patterns each separate one rule from its nearest fault: serial clock toggles with chip select high, a one-cycle chip-select glitch, a result strobe in mid-transfer followed by an empty transfer, and chip select held low while waiting for a result.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    WL_8  = 2'b00,
    WL_10 = 2'b01,
    WL_12 = 2'b10,
    WL_16 = 2'b11
  } wl_e;

  localparam int unsigned MAX_LEN = 16;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  function automatic logic [CNT_W-1:0] wl_len(wl_e w);
    case (w)
      WL_8:    return CNT_W'(8);
      WL_10:   return CNT_W'(10);
      WL_12:   return CNT_W'(12);
      default: return CNT_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/adc_sp_cs_filter.sv
module adc_sp_cs_filter #(
  parameter int unsigned GLITCH_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  output logic cs_low_o
);

  localparam int unsigned CW = $clog2(GLITCH_CYC + 1);

  logic          state_n_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_n_q <= 1'b1;
      cnt_q     <= '0;
    end else if (cs_n_i == state_n_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(GLITCH_CYC - 1)) begin
      state_n_q <= cs_n_i;
      cnt_q     <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cs_low_o = ~state_n_q;

  generate
    if (GLITCH_CYC >= 2) begin : g_chk
      // new level must have been present on the input for the last two cycles
      assert_cs_deglitch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_n_q != $past(state_n_q)) |->
          ($past(cs_n_i) == state_n_q && $past(cs_n_i, 2) == state_n_q));
    end
  endgenerate

endmodule

// File: rtl/adc_sp_core.sv
module adc_sp_core
  import adc_sp_pkg::*;
#(
  parameter int unsigned RES_W    = 10,
  parameter int unsigned IN_W     = 8,
  parameter int unsigned MSBF_POS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_low_i,
  input  logic             sclk_i,
  input  logic             din_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             res_vld_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic [IN_W-1:0]  cfg_word_o,
  output logic             cfg_msbf_o,
  output logic [1:0]       cfg_wl_o,
  output logic             cfg_valid_o
);

  localparam int unsigned IDX_W     = $clog2(RES_W);
  localparam int unsigned MSBF_IDX  = IN_W - 1 - MSBF_POS;   // position in pre-shift register

  logic                sclk_d_q, cs_low_d_q;
  logic                sclk_rise, sclk_fall, cs_end, busy;
  logic [CNT_W-1:0]    rise_cnt_q, out_idx_q, cur_len;
  logic [IN_W-2:0]     in_sr_q;
  logic [IN_W-1:0]     cfg_word_q;
  logic                cfg_done_q, cfg_valid_q, msbf_next_q, order_q, fresh_q;
  wl_e                 wl_q;
  logic [RES_W-1:0]    res_q, res_rev, res_sel;

  assign sclk_rise = sclk_i & ~sclk_d_q;
  assign sclk_fall = ~sclk_i & sclk_d_q;
  assign cs_end    = cs_low_d_q & ~cs_low_i;
  assign busy      = cs_low_i & (rise_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q    <= 1'b0;
      cs_low_d_q  <= 1'b0;
      rise_cnt_q  <= '0;
      out_idx_q   <= '0;
      in_sr_q     <= '0;
      cfg_word_q  <= '0;
      cfg_done_q  <= 1'b0;
      cfg_valid_q <= 1'b0;
      msbf_next_q <= 1'b1;
      order_q     <= 1'b1;
      fresh_q     <= 1'b0;
      wl_q        <= WL_16;
      res_q       <= '0;
    end else begin
      sclk_d_q    <= sclk_i;
      cs_low_d_q  <= cs_low_i;
      cfg_valid_q <= 1'b0;
      if (cs_end) begin
        rise_cnt_q <= '0;
        out_idx_q  <= '0;
        cfg_done_q <= 1'b0;
        if (rise_cnt_q != '0) begin
          fresh_q <= 1'b0;
          if (cfg_done_q) order_q <= msbf_next_q;
        end
      end else if (cs_low_i) begin
        if (sclk_rise) begin
          if (rise_cnt_q != CNT_W'(MAX_LEN)) rise_cnt_q <= rise_cnt_q + 1'b1;
          if (rise_cnt_q < CNT_W'(IN_W)) begin
            in_sr_q <= {in_sr_q[IN_W-3:0], din_i};
            if (rise_cnt_q == CNT_W'(IN_W - 1)) begin
              cfg_done_q  <= 1'b1;
              cfg_valid_q <= 1'b1;
              cfg_word_q  <= {in_sr_q, din_i};
              msbf_next_q <= in_sr_q[MSBF_IDX];
              wl_q        <= wl_e'({in_sr_q[0], din_i});
            end
          end
        end
        if (sclk_fall && (out_idx_q < rise_cnt_q)) out_idx_q <= out_idx_q + 1'b1;
      end
      if (res_vld_i && !busy) begin
        res_q   <= res_i;
        fresh_q <= 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < int'(RES_W); g++) begin : g_rev
      assign res_rev[g] = res_q[RES_W-1-g];
    end
  endgenerate

  assign res_sel   = order_q ? res_rev : res_q;
  assign cur_len   = cfg_done_q ? wl_len(wl_q) : CNT_W'(MAX_LEN);
  assign dout_oe_o = cs_low_i & fresh_q & (out_idx_q < cur_len);
  assign dout_o    = (out_idx_q < CNT_W'(RES_W)) ? res_sel[out_idx_q[IDX_W-1:0]] : 1'b0;

  assign cfg_word_o  = cfg_word_q;
  assign cfg_msbf_o  = msbf_next_q;
  assign cfg_wl_o    = wl_q;
  assign cfg_valid_o = cfg_valid_q;

  assert_sclk_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_low_i && !$past(cs_low_i)) |-> (rise_cnt_q == '0 && out_idx_q == '0));

  assert_cfg_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |=> !cfg_valid_o);

  assert_out_behind_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_idx_q <= rise_cnt_q);

  assert_order_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_low_i |=> $stable(order_q));

  assert_no_load_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy) |-> $stable(res_q));

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int unsigned RES_W       = 10,
  parameter int unsigned IN_W        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GLITCH_CYC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             din_i,
  output wire              dout_o,
  output logic             dout_oe_o,
  input  logic [RES_W-1:0] res_i,
  input  logic             res_vld_i,
  output logic [IN_W-1:0]  cfg_word_o,
  output logic             cfg_msbf_o,
  output logic [1:0]       cfg_wl_o,
  output logic             cfg_valid_o
);

  logic [2:0] pins_s;
  logic       cs_low, dout_bit;

  adc_sp_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   (pins_s)
  );

  adc_sp_cs_filter #(
    .GLITCH_CYC(GLITCH_CYC)
  ) u_cs_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_i  (pins_s[2]),
    .cs_low_o(cs_low)
  );

  adc_sp_core #(
    .RES_W   (RES_W),
    .IN_W    (IN_W),
    .MSBF_POS(6)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_low_i   (cs_low),
    .sclk_i     (pins_s[1]),
    .din_i      (pins_s[0]),
    .res_i      (res_i),
    .res_vld_i  (res_vld_i),
    .dout_o     (dout_bit),
    .dout_oe_o  (dout_oe_o),
    .cfg_word_o (cfg_word_o),
    .cfg_msbf_o (cfg_msbf_o),
    .cfg_wl_o   (cfg_wl_o),
    .cfg_valid_o(cfg_valid_o)
  );

  assign dout_o = dout_oe_o ? dout_bit : 1'bz;

endmodule

// File: tb/sim_adc_serial_port.sv
`timescale 1ns/1ps
module sim_adc_serial_port;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, sclk_i = 1'b0, din_i = 1'b0;
  logic [9:0] res_i = '0;
  logic       res_vld_i = 1'b0;
  wire        dout_o;
  logic       dout_oe_o, cfg_msbf_o, cfg_valid_o;
  logic [7:0] cfg_word_o;
  logic [1:0] cfg_wl_o;

  int n_cmp = 0, n_bad = 0, n_cfg = 0;
  bit ord_model = 1'b1;

  always #4 clk = ~clk;

  adc_serial_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .din_i(din_i),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .res_i(res_i), .res_vld_i(res_vld_i),
    .cfg_word_o(cfg_word_o), .cfg_msbf_o(cfg_msbf_o), .cfg_wl_o(cfg_wl_o),
    .cfg_valid_o(cfg_valid_o)
  );

  always @(posedge clk) if (rst_ni && cfg_valid_o) n_cfg++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [9:0] v);
    @(negedge clk);
    res_i = v; res_vld_i = 1'b1;
    @(negedge clk);
    res_vld_i = 1'b0;
  endtask

  function automatic int len_of(input logic [1:0] wl);
    case (wl)
      2'b00: return 8;
      2'b01: return 10;
      2'b10: return 12;
      default: return 16;
    endcase
  endfunction

  function automatic logic exp_bit(input logic [9:0] r, input bit ord, input int k);
    if (k >= 10) return 1'b0;
    return ord ? r[9-k] : r[k];
  endfunction

  // drive: oe_exp=0 means the whole word must stay released
  task automatic xfer(input logic [7:0] word, input logic [9:0] r, input bit oe_exp,
                      input int strobe_at, input logic [9:0] strobe_val);
    int len;
    int cfg0;
    len  = len_of(word[1:0]);
    cfg0 = n_cfg;
    @(negedge clk); cs_ni = 1'b0;
    wclk(10);
    for (int i = 0; i < len; i++) begin
      din_i = (i < 8) ? word[7-i] : 1'b0;
      wclk(HALF);
      if (oe_exp)
        chk(dout_oe_o === 1'b1 && dout_o === exp_bit(r, ord_model, i),
            ord_model ? "R6 R8 bit" : "R7 R8 bit",
            {dout_oe_o, dout_o}, {1'b1, exp_bit(r, ord_model, i)});
      else
        chk(dout_oe_o === 1'b0, "R9 released", dout_oe_o, 0);
      sclk_i = 1'b1;
      wclk(HALF);
      sclk_i = 1'b0;
      if (i == strobe_at) load(strobe_val);
    end
    wclk(HALF);
    chk(dout_oe_o === 1'b0, "R5 release after length", dout_oe_o, 0);
    @(negedge clk); cs_ni = 1'b1;
    wclk(12);
    chk(cfg_word_o == word, "R4 word", cfg_word_o, word);
    chk(cfg_msbf_o == word[2] && cfg_wl_o == word[1:0], "R4 fields",
        {cfg_msbf_o, cfg_wl_o}, {word[2], word[1:0]});
    chk(n_cfg == cfg0 + 1, "R4 pulse", n_cfg - cfg0, 1);
    ord_model = word[2];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] r;
    logic [7:0] w8;
    wclk(3);
    chk(dout_oe_o === 1'b0, "R1 oe", dout_oe_o, 0);
    chk(cfg_valid_o === 1'b0, "R1 cfg_valid", cfg_valid_o, 0);
    rst_ni = 1'b1;
    wclk(3);
    chk(dout_oe_o === 1'b0, "R1 oe after release", dout_oe_o, 0);

    // main sweep: both orders, all lengths, several results
    for (int o = 0; o < 2; o++)
      for (int w = 0; w < 4; w++)
        for (int v = 0; v < 3; v++) begin
          r  = 10'(v * 389 + w * 97 + o * 211 + 5);
          w8 = {5'(v * 7 + w), 1'((v + w + o) & 1), 2'(w)};
          load(r);
          xfer(w8, r, 1'b1, -1, '0);
        end

    // R2: serial clock with chip select high changes nothing
    load(10'h2C9);
    for (int i = 0; i < 6; i++) begin
      din_i = 1'b1; sclk_i = 1'b1; wclk(HALF);
      chk(dout_oe_o === 1'b0, "R2 released", dout_oe_o, 0);
      sclk_i = 1'b0; wclk(HALF);
    end
    xfer(8'b10101_1_11, 10'h2C9, 1'b1, -1, '0);

    // R3: one-cycle chip select glitch
    load(10'h155);
    @(negedge clk); cs_ni = 1'b0;
    @(negedge clk); cs_ni = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(dout_oe_o === 1'b0, "R3 glitch ignored", dout_oe_o, 0);
    end
    xfer(8'b00011_0_10, 10'h155, 1'b1, -1, '0);

    // R9: strobe during transfer is dropped
    load(10'h0F3);
    xfer(8'b11100_1_11, 10'h0F3, 1'b1, 2, 10'h30C);
    xfer(8'b01010_1_00, 10'h000, 1'b0, -1, '0);

    // R10: chip select low while waiting for the result
    @(negedge clk); cs_ni = 1'b0;
    wclk(20);
    chk(dout_oe_o === 1'b0, "R10 waiting", dout_oe_o, 0);
    load(10'h3A6);
    wclk(2);
    chk(dout_oe_o === 1'b1 && dout_o === exp_bit(10'h3A6, ord_model, 0), "R10 first bit",
        {dout_oe_o, dout_o}, {1'b1, exp_bit(10'h3A6, ord_model, 0)});
    xfer(8'b00110_0_01, 10'h3A6, 1'b1, -1, '0);

    // LSB order now in effect: 8-bit truncated word
    load(10'h2B7);
    xfer(8'b00001_1_00, 10'h2B7, 1'b1, -1, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule